// File: doc/BRIEF.md
# Endian-Aware Byte Packer for a Serial Controller's Data Path

This block sits between a 32-bit register port and two byte-wide FIFOs of a serial peripheral controller. A transmit access writes one data word. The block slices that word into bytes and pushes them, one per clock, into the transmit FIFO. A receive access pops bytes, one per clock, from the receive FIFO and gathers them into one data word for the register read. The FIFO storage, the serial shifter and chip selects are outside this block.

Byte order comes from one bit of the configuration word, read at the start of each access. For a transmit access, the caller chooses how many bytes to move. It either names the main data register, which uses the configured transfer width, or names one of the narrow aliases, which move exactly 1, 2 or 3 bytes. Receive accesses always use the configured width. An access stops early when the FIFO cannot take or give another byte. The block then reports one done pulse and the number of bytes it moved. A short receive in little-endian order is moved up inside the word. This keeps the received bytes packed against the top of the word.

Top module: `spwp_top`

## Requirements
- R1: Bit 26 of `cfg_reg` selects big-endian order when 1 and little-endian order when 0. The value is captured when the access starts, so later changes to `cfg_reg` have no effect on an access already under way.
- R2: In big-endian order, a transmit access sends bits 31:24 of the word first, then bits 23:16, and so on toward bit 0.
- R3: In little-endian order, a transmit access sends bits 7:0 of the word first, then bits 15:8, and so on toward bit 31.
- R4: A transmit access stops, without any error, the first cycle `tx_full` is high. The bytes not yet sent are dropped, and `done_count` gives the number actually pushed.
- R5: When `acc_sel` is 0, a transmit access moves `cfg_width` bytes. A `cfg_width` of 0, or of more than 4, moves 4 bytes.
- R6: When `acc_sel` is 1, 2 or 3, a transmit access moves exactly that many bytes, whatever the value of `cfg_width`.
- R7: A receive access pops up to the configured width (with the same 0/over-4 rule as R5) and ignores `acc_sel`. It stops the first cycle `rx_empty` is high, leaves any further bytes in the FIFO, and byte slots that were not filled read as zero.
- R8: In little-endian order, a receive places the k-th popped byte (counting from 0) at bits 8k+7:8k. It then shifts the word left by 8 times the shortfall, where the shortfall is the requested count minus the popped count.
- R9: In big-endian order, a receive places the k-th popped byte at bits 31-8k:24-8k and applies no shortfall shift.
- R10: At most one byte moves per clock. `acc_ready` is low from the cycle after an accepted start until the access finishes. An access that moves all n requested bytes raises `done` n cycles after the start edge. An access stopped by the FIFO raises `done` n+1 cycles after the start edge.
- R11: `done` is high for exactly one cycle per access. In that cycle `done_count` equals the bytes moved, and for a receive `rd_data` holds the assembled word.
- R12: During and right after reset, `acc_ready` is 1 and `tx_push`, `rx_pop` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_reg | input | 32 | Configuration word; bit 26 is the byte-order select |
| cfg_width | input | 3 | Configured transfer width in bytes (0 and values above 4 mean 4) |
| acc_start | input | 1 | Start an access; accepted when `acc_ready` is high |
| acc_read | input | 1 | 1 = receive access, 0 = transmit access |
| acc_sel | input | 2 | Transmit register choice: 0 main, 1 to 3 narrow alias |
| acc_wdata | input | 32 | Word to transmit |
| acc_ready | output | 1 | Block idle and able to accept a start |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO this cycle |
| tx_byte | output | 8 | Byte presented to the transmit FIFO |
| tx_full | input | 1 | Transmit FIFO cannot take a byte |
| rx_pop | output | 1 | Pop the head of the receive FIFO this cycle |
| rx_byte | input | 8 | Head byte of the receive FIFO (show-ahead) |
| rx_empty | input | 1 | Receive FIFO holds no byte |
| done | output | 1 | One-cycle pulse at the end of an access |
| done_count | output | 3 | Bytes moved by the access just finished |
| rd_data | output | 32 | Assembled receive word, updated when a receive finishes |

## Verification
Each access is accepted on the start edge. A byte then moves on each of the next edges, and `done` rises after the last move edge. That is n cycles after the start edge when all n bytes move, or n+1 cycles when a FIFO limit is hit. The bench records the cycle of each start and computes the due latency from the requested and available byte counts. The monitor samples `done` on falling edges and requires the observed cycle difference to match exactly. It also checks that `acc_ready` went low one cycle after the start. The FIFO models apply each push or pop just after the rising edge that commits it. This way the byte log and the remaining receive depth compared at `done` reflect exactly the transfers of that access.

// File: rtl/spwp_pkg.sv
package spwp_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_MOVE = 1'b1
   } spwp_state_e;

   // Resolve the byte count of one access from the alias choice and the
   // configured width; zero or oversize widths fall back to a full word.
   function automatic int unsigned spwp_pick_count(input int unsigned sel,
                                                   input int unsigned cfg_w,
                                                   input int unsigned nbytes,
                                                   input bit          is_read);
      int unsigned r;
      if (!is_read && sel != 0) r = (sel > nbytes) ? nbytes : sel;
      else if (cfg_w == 0 || cfg_w > nbytes) r = nbytes;
      else r = cfg_w;
      return r;
   endfunction

endpackage

// File: rtl/spwp_ctrl.sv
module spwp_ctrl
   import spwp_pkg::*;
#(
   parameter int NBYTES = 4,
   parameter int CNT_W  = $clog2(NBYTES + 1),
   parameter int SEL_W  = $clog2(NBYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_start,
   input  logic             acc_read,
   input  logic [SEL_W-1:0] acc_sel,
   input  logic [CNT_W-1:0] cfg_width,
   input  logic             be_in,
   input  logic             tx_full,
   input  logic             rx_empty,
   output logic             ready,
   output logic             load,
   output logic             is_read_q,
   output logic             be_q,
   output logic             move,
   output logic             finish,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] count_next,
   output logic [CNT_W-1:0] req_q,
   output logic             done,
   output logic [CNT_W-1:0] done_count
);

   spwp_state_e      state_q;
   logic [CNT_W-1:0] rem_q;
   logic [CNT_W-1:0] req_d;
   logic             blocked;

   always_comb begin
      req_d = CNT_W'(spwp_pick_count(int'(acc_sel), int'(cfg_width),
                                     NBYTES, acc_read));
   end

   assign ready      = (state_q == ST_IDLE);
   assign load       = ready && acc_start;
   assign blocked    = is_read_q ? rx_empty : tx_full;
   assign move       = (state_q == ST_MOVE) && !blocked;
   assign finish     = (state_q == ST_MOVE) && (blocked || rem_q == CNT_W'(1));
   assign count_next = count_q + CNT_W'(move);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         rem_q      <= '0;
         req_q      <= '0;
         count_q    <= '0;
         is_read_q  <= 1'b0;
         be_q       <= 1'b0;
         done       <= 1'b0;
         done_count <= '0;
      end else begin
         done <= finish;
         if (finish) done_count <= count_next;
         if (load) begin
            state_q   <= ST_MOVE;
            rem_q     <= req_d;
            req_q     <= req_d;
            count_q   <= '0;
            is_read_q <= acc_read;
            be_q      <= be_in;
         end else if (state_q == ST_MOVE) begin
            if (move) begin
               rem_q   <= rem_q - CNT_W'(1);
               count_q <= count_next;
            end
            if (finish) state_q <= ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/spwp_tx_slicer.sv
module spwp_tx_slicer #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic              be,
   input  logic              shift,
   output logic [BYTE_W-1:0] byte_out
);

   logic [DATA_W-1:0] word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
      end else if (load) begin
         word_q <= load_word;
      end else if (shift) begin
         word_q <= be ? (word_q << BYTE_W) : (word_q >> BYTE_W);
      end
   end

   assign byte_out = be ? word_q[DATA_W-1 -: BYTE_W] : word_q[BYTE_W-1:0];

endmodule

// File: rtl/spwp_rx_assembler.sv
module spwp_rx_assembler #(
   parameter int DATA_W = 32,
   parameter int BYTE_W = 8,
   parameter int NBYTES = DATA_W / BYTE_W,
   parameter int CNT_W  = $clog2(NBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              capture,
   input  logic [CNT_W-1:0]  lane_idx,
   input  logic [BYTE_W-1:0] byte_in,
   input  logic              finish_rd,
   input  logic              be,
   input  logic [CNT_W-1:0]  req,
   input  logic [CNT_W-1:0]  got,
   output logic [DATA_W-1:0] rd_data
);

   logic [BYTE_W-1:0] lane_q [NBYTES];
   logic [BYTE_W-1:0] lane_d [NBYTES];
   logic [DATA_W-1:0] le_word;
   logic [DATA_W-1:0] be_word;
   logic [CNT_W-1:0]  shortfall;

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      always_comb begin
         if (clear) lane_d[g] = '0;
         else if (capture && lane_idx == CNT_W'(g)) lane_d[g] = byte_in;
         else lane_d[g] = lane_q[g];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lane_q[g] <= '0;
         else        lane_q[g] <= lane_d[g];
      end
      assign le_word[g*BYTE_W +: BYTE_W]              = lane_d[g];
      assign be_word[(NBYTES-1-g)*BYTE_W +: BYTE_W]   = lane_d[g];
   end

   assign shortfall = req - got;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (finish_rd) begin
         rd_data <= be ? be_word : (le_word << (BYTE_W * int'(shortfall)));
      end
   end

endmodule

// File: rtl/spwp_top.sv
module spwp_top
   import spwp_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int BYTE_W     = 8,
   parameter int CFG_W      = 32,
   parameter int ENDIAN_BIT = 26,
   parameter int NBYTES     = DATA_W / BYTE_W,
   parameter int CNT_W      = $clog2(NBYTES + 1),
   parameter int SEL_W      = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CFG_W-1:0]  cfg_reg,
   input  logic [CNT_W-1:0]  cfg_width,
   input  logic              acc_start,
   input  logic              acc_read,
   input  logic [SEL_W-1:0]  acc_sel,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              acc_ready,
   output logic              tx_push,
   output logic [BYTE_W-1:0] tx_byte,
   input  logic              tx_full,
   output logic              rx_pop,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              rx_empty,
   output logic              done,
   output logic [CNT_W-1:0]  done_count,
   output logic [DATA_W-1:0] rd_data
);

   if (DATA_W % BYTE_W != 0) begin : g_bad_ratio
      $error("spwp_top: DATA_W must be a multiple of BYTE_W");
   end
   if (NBYTES < 2) begin : g_bad_nbytes
      $error("spwp_top: at least two bytes per word are required");
   end
   if (ENDIAN_BIT >= CFG_W) begin : g_bad_endian
      $error("spwp_top: ENDIAN_BIT outside the configuration word");
   end

   logic             load;
   logic             is_read_q;
   logic             be_q;
   logic             move;
   logic             finish;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_next;
   logic [CNT_W-1:0] req_q;

   spwp_ctrl #(
      .NBYTES (NBYTES),
      .CNT_W  (CNT_W),
      .SEL_W  (SEL_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_start  (acc_start),
      .acc_read   (acc_read),
      .acc_sel    (acc_sel),
      .cfg_width  (cfg_width),
      .be_in      (cfg_reg[ENDIAN_BIT]),
      .tx_full    (tx_full),
      .rx_empty   (rx_empty),
      .ready      (acc_ready),
      .load       (load),
      .is_read_q  (is_read_q),
      .be_q       (be_q),
      .move       (move),
      .finish     (finish),
      .count_q    (count_q),
      .count_next (count_next),
      .req_q      (req_q),
      .done       (done),
      .done_count (done_count)
   );

   assign tx_push = move && !is_read_q;
   assign rx_pop  = move &&  is_read_q;

   spwp_tx_slicer #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W)
   ) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (acc_wdata),
      .be        (be_q),
      .shift     (tx_push),
      .byte_out  (tx_byte)
   );

   spwp_rx_assembler #(
      .DATA_W (DATA_W),
      .BYTE_W (BYTE_W),
      .NBYTES (NBYTES),
      .CNT_W  (CNT_W)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (load),
      .capture   (rx_pop),
      .lane_idx  (count_q),
      .byte_in   (rx_byte),
      .finish_rd (finish && is_read_q),
      .be        (be_q),
      .req       (req_q),
      .got       (count_next),
      .rd_data   (rd_data)
   );

endmodule

// File: rtl/spwp_checker.sv
module spwp_checker #(
   parameter int NBYTES = 4,
   parameter int CNT_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_start,
   input logic             acc_ready,
   input logic             tx_push,
   input logic             tx_full,
   input logic             rx_pop,
   input logic             rx_empty,
   input logic             done,
   input logic [CNT_W-1:0] done_count
);

   logic [CNT_W:0] moved_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) moved_q <= '0;
      else if (acc_start && acc_ready) moved_q <= '0;
      else if (tx_push || rx_pop) moved_q <= moved_q + 1'b1;
   end

   p_push_not_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> !tx_full);

   p_pop_not_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> !rx_empty);

   p_one_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_push && rx_pop));

   p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_push || rx_pop) |-> !acc_ready);

   p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> acc_ready);

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_count_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, done_count} == moved_q));

   p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(done_count) <= NBYTES));

endmodule

bind spwp_top spwp_checker #(
   .NBYTES (NBYTES),
   .CNT_W  (CNT_W)
) u_spwp_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_start  (acc_start),
   .acc_ready  (acc_ready),
   .tx_push    (tx_push),
   .tx_full    (tx_full),
   .rx_pop     (rx_pop),
   .rx_empty   (rx_empty),
   .done       (done),
   .done_count (done_count)
);

// File: tb/spwp_top_bench.sv
module spwp_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cfg_reg = '0;
   logic [2:0]  cfg_width = '0;
   logic        acc_start = 1'b0;
   logic        acc_read = 1'b0;
   logic [1:0]  acc_sel = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_ready;
   logic        tx_push;
   logic [7:0]  tx_byte;
   logic        tx_full = 1'b0;
   logic        rx_pop;
   logic [7:0]  rx_byte = '0;
   logic        rx_empty = 1'b1;
   logic        done;
   logic [2:0]  done_count;
   logic [31:0] rd_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   spwp_top u_spwp_top (
      .clk(clk), .rst_n(rst_n), .cfg_reg(cfg_reg), .cfg_width(cfg_width),
      .acc_start(acc_start), .acc_read(acc_read), .acc_sel(acc_sel),
      .acc_wdata(acc_wdata), .acc_ready(acc_ready), .tx_push(tx_push),
      .tx_byte(tx_byte), .tx_full(tx_full), .rx_pop(rx_pop), .rx_byte(rx_byte),
      .rx_empty(rx_empty), .done(done), .done_count(done_count), .rd_data(rd_data)
   );

   typedef struct {
      string       tag;
      bit          is_read;
      int          count;
      logic [31:0] bytes;   // tx: byte k at [8k+:8]
      logic [31:0] rdata;
      int          lat;
      int          start_cyc;
      int          rx_left;
   } exp_t;

   exp_t       expq[$];
   logic [7:0] txlog[$];
   logic [7:0] rxq[$];
   int         tx_used = 0;
   int         tx_cap  = 100;
   int         cyc = 0;
   int         n_chk = 0;
   int         n_bad = 0;
   logic       pend_push = 0, pend_pop = 0;
   logic [7:0] pend_byte = '0;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic refresh();
      tx_full  = (tx_used >= tx_cap);
      rx_empty = (rxq.size() == 0);
      rx_byte  = (rxq.size() != 0) ? rxq[0] : 8'h00;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      pend_push = tx_push;
      pend_pop  = rx_pop;
      pend_byte = tx_byte;
   end

   always @(posedge clk) begin
      #1;
      if (pend_push) begin txlog.push_back(pend_byte); tx_used++; end
      if (pend_pop && rxq.size() != 0) void'(rxq.pop_front());
      pend_push = 0;
      pend_pop  = 0;
      refresh();
   end

   // Monitor: compares each finished access against the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (expq.size() == 0) begin
            check("R11 unexpected done", 32'd1, 32'd0);
         end else begin
            exp_t e;
            e = expq.pop_front();
            check({e.tag, " count"}, 32'(done_count), 32'(e.count));
            check({e.tag, " R10 latency"}, 32'(cyc - e.start_cyc), 32'(e.lat + 1));
            check({e.tag, " R10 ready at done"}, 32'(acc_ready), 32'd1);
            if (e.is_read) begin
               check({e.tag, " rd_data"}, rd_data, e.rdata);
               check({e.tag, " R7 rx left"}, 32'(rxq.size()), 32'(e.rx_left));
            end else begin
               check({e.tag, " tx bytes pushed"}, 32'(txlog.size()), 32'(e.count));
               for (int k = 0; k < e.count && k < txlog.size(); k++)
                  check({e.tag, " tx byte"}, 32'(txlog[k]), 32'(e.bytes[8*k +: 8]));
            end
         end
         txlog.delete();
      end
   end

   task automatic load_rx(int n, logic [31:0] b);
      rxq.delete();
      for (int k = 0; k < n; k++) rxq.push_back(b[8*k +: 8]);
      refresh();
   endtask

   task automatic do_access(string tag, bit rd, int sel, int width, bit be,
                            logic [31:0] word, int cap, bit flip);
      exp_t e;
      int req, avail, n;
      logic [31:0] acc;
      @(negedge clk);
      tx_used = 0;
      tx_cap  = cap;
      refresh();
      if (!rd && sel != 0) req = sel;
      else if (width == 0 || width > 4) req = 4;
      else req = width;
      avail = rd ? rxq.size() : cap;
      n = (avail < req) ? avail : req;
      e.tag = tag; e.is_read = rd; e.count = n;
      e.lat = (n == req) ? n : n + 1;
      e.start_cyc = cyc;
      e.rx_left = rd ? rxq.size() - n : 0;
      e.bytes = '0; acc = '0;
      for (int k = 0; k < n; k++) begin
         if (rd) begin
            if (be) acc[8*(3-k) +: 8] = rxq[k];
            else    acc[8*k +: 8]     = rxq[k];
         end else begin
            e.bytes[8*k +: 8] = be ? word[8*(3-k) +: 8] : word[8*k +: 8];
         end
      end
      if (rd && !be) acc = acc << (8 * (req - n));
      e.rdata = acc;
      expq.push_back(e);
      cfg_reg   = be ? 32'h0400_0000 : 32'h0000_0000;
      cfg_width = 3'(width);
      acc_read  = rd;
      acc_sel   = 2'(sel);
      acc_wdata = word;
      acc_start = 1'b1;
      @(negedge clk);
      acc_start = 1'b0;
      if (flip) cfg_reg = be ? 32'h0000_0000 : 32'h0400_0000;   // R1 latch
      check({tag, " R10 ready low"}, 32'(acc_ready), 32'd0);
      wait (expq.size() == 0);
      @(negedge clk);
   endtask

   task automatic run_tests();
      @(negedge clk);
      check("R12 ready in reset", 32'(acc_ready), 32'd1);
      check("R12 no push/pop in reset", 32'({tx_push, rx_pop}), 32'd0);
      check("R12 done in reset", 32'(done), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 ready after reset", 32'(acc_ready), 32'd1);
      check("R12 done after reset", 32'(done), 32'd0);
      do_access("R2 R5 be w4",     0, 0, 4, 1, 32'hA1B2C3D4, 100, 0);
      do_access("R3 R5 le w4",     0, 0, 4, 0, 32'hA1B2C3D4, 100, 0);
      do_access("R6 alias1 le",    0, 1, 4, 0, 32'h11223344, 100, 0);
      do_access("R6 alias2 be",    0, 2, 1, 1, 32'h11223344, 100, 0);
      do_access("R6 alias3 le",    0, 3, 2, 0, 32'h11223344, 100, 0);
      do_access("R5 width0",       0, 0, 0, 0, 32'h55667788, 100, 0);
      do_access("R5 width6",       0, 0, 6, 1, 32'h55667788, 100, 0);
      do_access("R5 width2",       0, 0, 2, 1, 32'h55667788, 100, 0);
      do_access("R4 full at 2",    0, 0, 4, 1, 32'hCAFEF00D, 2, 0);
      do_access("R4 full at 0",    0, 0, 4, 0, 32'hCAFEF00D, 0, 0);
      do_access("R1 latch le",     0, 0, 4, 0, 32'h0A0B0C0D, 100, 1);
      do_access("R1 latch be",     0, 0, 3, 1, 32'h0A0B0C0D, 100, 1);
      load_rx(4, 32'h04030201);
      do_access("R8 rx le full",   1, 0, 4, 0, 32'h0, 100, 0);
      load_rx(4, 32'h04030201);
      do_access("R9 rx be full",   1, 0, 4, 1, 32'h0, 100, 1);
      load_rx(2, 32'h0000BBAA);
      do_access("R8 rx le short",  1, 0, 4, 0, 32'h0, 100, 0);
      load_rx(2, 32'h0000BBAA);
      do_access("R9 rx be short",  1, 0, 0, 1, 32'h0, 100, 0);
      load_rx(4, 32'hDDCCBBAA);
      do_access("R7 rx w2 sel ignored", 1, 3, 2, 0, 32'h0, 100, 0);
      load_rx(1, 32'h0000005A);
      do_access("R8 rx le w3 short", 1, 0, 3, 0, 32'h0, 100, 0);
      load_rx(0, 32'h0);
      do_access("R7 rx empty",     1, 0, 4, 0, 32'h0, 100, 0);
   endtask

   initial begin
      refresh();
      fork
         run_tests();
         begin
            repeat (WATCHDOG) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule